// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit programmable timer channel. Software writes a control word that selects one of six operating modes, then writes an initial count. The channel advances once for every enabled counter-clock strobe and drives an output whose waveform depends on the mode. The six waveforms are a level that rises at terminal count, a retriggerable one-shot, a periodic single-count rate pulse, a square wave, and two single-count strobes, one started by software and one by the gate. The current count is always visible for readback, and the output level and effective mode are available for status.

The counter clock arrives as a one-cycle strobe `tick` in the system clock domain. The `gate` input is asynchronous and passes through a synchronizer. In the terminal-count and software-strobe modes the gate level enables or pauses counting. In the other four modes a rising gate edge restarts the count from the loaded value. Host bus decoding, byte sequencing and BCD arithmetic belong to the surrounding logic. The BCD flag is only stored and reflected.

Top module: `interval_counter_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_o`=0, `count_o`=0 and `mode_o`=0, with no count armed.
- R2: A loaded value of 0 counts as 65536: `count_o` reads 0 right after the load and 1 after 65535 ticks. In mode 0, `out_o` rises only after the 65536th tick.
- R3: `mode_o` shows the effective mode in the range 0..5. Raw mode 6 acts and reads as mode 2, and raw mode 7 acts and reads as mode 3. `bcd_o` returns the stored BCD flag.
- R4: Mode 0: after a load, `out_o` is low. It goes high on the tick where the elapsed count reaches the loaded value N, and it stays high.
- R5: In modes 0 and 4, a low synchronized gate pauses counting and a rising edge does not restart it. In modes 1, 2, 3 and 5, a rising gate edge sets the elapsed count back to 0, and the gate level does not pause counting.
- R6: Mode 1: `out_o` is high while the elapsed count is below N and low from the tick where it reaches N.
- R7: Mode 2: `out_o` is high exactly when the elapsed count is a nonzero multiple of N. `count_o` reads N minus (elapsed mod N).
- R8: Mode 3: `out_o` is high while (elapsed mod N) < (N+1)/2 and low otherwise. `count_o` reads N minus (2*elapsed mod N), so it steps down by two per tick.
- R9: Modes 4 and 5: `out_o` is high only while the elapsed count equals N. At that point `count_o` reads 0.
- R10: In modes 0, 1, 4 and 5, `count_o` equals (N minus elapsed) mod 65536 and keeps decrementing past zero.
- R11: A control write clears the armed state and forces `out_o` to the idle level: high for mode 3, low otherwise. Ticks are ignored until the next load. A load shows N on `count_o` in the following cycle, and the first tick after it decrements.
- R12: The channel advances only on cycles where `tick` is high. The gate is synchronized through two flops before it takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter-clock strobe, one system cycle per count |
| gate | input | 1 | Asynchronous gate input |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_mode | input | 3 | Raw mode field of the control word |
| ctl_bcd | input | 1 | BCD flag of the control word (stored only) |
| load_wr | input | 1 | Initial count write strobe |
| load_val | input | 16 | Initial count (0 means 65536) |
| count_o | output | 16 | Current readable count |
| out_o | output | 1 | Channel output level |
| mode_o | output | 3 | Effective mode for status |
| bcd_o | output | 1 | Stored BCD flag for status |

## Verification
The hardest case to reach is the full 65536-count span of a zero load, where the count has to pass through 1 and then wrap without the terminal output firing early. The bench holds `tick` high for one long burst of 65535 cycles and then adds one more tick. Gate retriggers are also hard to hit because of the synchronizer delay. The stimulus drops and raises `gate` with idle cycles in between, in the middle of a count, in both the edge-sensitive and the level-sensitive modes, and compares the restarted count with its value before the edge.

// File: rtl/pic_pkg.sv
// Shared types for the interval counter channel.
// Assumes a 3-bit raw mode field where codes 6 and 7 alias 2 and 3.
package pic_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pic_mode_e;

    // Fold the two aliased codes onto their base modes.
    function automatic pic_mode_e fold_mode(input logic [2:0] raw);
        if (raw > 3'd5) return pic_mode_e'(raw - 3'd4);
        return pic_mode_e'(raw);
    endfunction

    // Modes in which the gate level enables counting instead of retriggering.
    function automatic logic level_gated(input pic_mode_e m);
        return (m == M_TERM) || (m == M_SWSTROBE);
    endfunction

endpackage

// File: rtl/pic_gate_sync.sv
// Gate synchronizer and rising-edge detector.
// Assumes gate is asynchronous to clk. STAGES flops bring it into the
// clock domain, and one more flop finds the rising edge.
module pic_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_async,
    output logic gate_lvl,
    output logic gate_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the gate through synchronizer stage i.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else if (i == 0) sync_q[i] <= gate_async;
                else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign gate_lvl  = sync_q[STAGES-1];
    assign gate_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pic_count_core.sv
// Count state of one channel: mode register, loaded value, elapsed count,
// phase counters for the periodic modes, and the wrapping readback counter.
// Assumes tick is a one-cycle strobe in the clk domain. Priority is
// control write, then load, then gate retrigger, then tick.
module pic_count_core
    import pic_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gate_lvl,
    input  logic          gate_rise,
    input  logic          ctl_wr,
    input  logic [2:0]    ctl_mode,
    input  logic          ctl_bcd,
    input  logic          load_wr,
    input  logic [CW-1:0] load_val,
    output pic_mode_e     mode_q,
    output logic          bcd_q,
    output logic          armed_q,
    output logic [CW:0]   n_q,
    output logic [CW+1:0] el_q,
    output logic [CW:0]   ph_q,
    output logic [CW-1:0] count_rd
);
    localparam int NW = CW + 1;
    localparam int EW = CW + 2;
    localparam logic [NW-1:0] ONE_N  = NW'(1);
    localparam logic [EW-1:0] TWO_E  = EW'(2);
    localparam logic [EW-1:0] EL_MAX = {EW{1'b1}};

    logic [NW-1:0] ph2_q;
    logic [CW-1:0] cnt_q;
    logic [NW-1:0] load_n;
    logic          adv;
    logic          retrig;
    logic [NW-1:0] ph_nx;
    logic [EW-1:0] sq0, sq1, sq2;
    logic [NW-1:0] rd_full;

    // Turn the written value into N, with zero standing for 2^CW.
    assign load_n = (load_val == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, load_val};

    // Decide whether this cycle restarts or advances the count.
    always_comb begin
        retrig = armed_q && gate_rise && !level_gated(mode_q);
        adv    = armed_q && tick && (gate_lvl || !level_gated(mode_q));
    end

    // Next values of the two phase counters, kept modulo N.
    always_comb begin
        ph_nx = (ph_q == n_q - ONE_N) ? '0 : ph_q + ONE_N;
        sq0   = {1'b0, ph2_q} + TWO_E;
        sq1   = (sq0 >= {1'b0, n_q}) ? sq0 - {1'b0, n_q} : sq0;
        sq2   = (sq1 >= {1'b0, n_q}) ? sq1 - {1'b0, n_q} : sq1;
    end

    // Update the channel state in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_TERM;
            bcd_q   <= 1'b0;
            armed_q <= 1'b0;
            n_q     <= '0;
            el_q    <= '0;
            ph_q    <= '0;
            ph2_q   <= '0;
            cnt_q   <= '0;
        end else if (ctl_wr) begin
            mode_q  <= fold_mode(ctl_mode);
            bcd_q   <= ctl_bcd;
            armed_q <= 1'b0;
            el_q    <= '0;
            ph_q    <= '0;
            ph2_q   <= '0;
        end else if (load_wr) begin
            armed_q <= 1'b1;
            n_q     <= load_n;
            el_q    <= '0;
            ph_q    <= '0;
            ph2_q   <= '0;
            cnt_q   <= load_n[CW-1:0];
        end else if (retrig) begin
            el_q    <= '0;
            ph_q    <= '0;
            ph2_q   <= '0;
            cnt_q   <= n_q[CW-1:0];
        end else if (adv) begin
            el_q    <= (el_q == EL_MAX) ? el_q : el_q + EW'(1);
            ph_q    <= ph_nx;
            ph2_q   <= sq2[NW-1:0];
            cnt_q   <= cnt_q - CW'(1);
        end
    end

    // Pick the readable count for the current mode.
    always_comb begin
        rd_full = {1'b0, cnt_q};
        if (armed_q) begin
            case (mode_q)
                M_RATE:   rd_full = n_q - ph_q;
                M_SQUARE: rd_full = n_q - ph2_q;
                default:  rd_full = {1'b0, cnt_q};
            endcase
        end
        count_rd = rd_full[CW-1:0];
    end
endmodule

// File: rtl/pic_wave_out.sv
// Output waveform generator. A pure function of the count state.
// Assumes el never wraps (it saturates) and ph is the elapsed count mod N.
module pic_wave_out
    import pic_pkg::*;
#(
    parameter int CW = 16
) (
    input  pic_mode_e     mode,
    input  logic          armed,
    input  logic [CW:0]   n,
    input  logic [CW+1:0] el,
    input  logic [CW:0]   ph,
    output logic          out
);
    localparam int NW = CW + 1;
    logic [NW:0]   half;
    logic [CW+1:0] n_ext;

    // Work out the high-phase length of the square wave and the widened N.
    always_comb begin
        half  = ({1'b0, n} + (NW+1)'(1)) >> 1;
        n_ext = {1'b0, n};
    end

    // Select the level for the current mode, or the idle level if not armed.
    always_comb begin
        if (!armed) begin
            out = (mode == M_SQUARE);
        end else begin
            case (mode)
                M_TERM:    out = (el >= n_ext);
                M_ONESHOT: out = (el < n_ext);
                M_RATE:    out = (ph == '0) && (el != '0);
                M_SQUARE:  out = ({1'b0, ph} < half);
                default:   out = (el == n_ext);
            endcase
        end
    end
endmodule

// File: rtl/interval_counter_channel.sv
// Top of one programmable interval counter channel.
// Assumes the host side has already assembled full control words and
// counts. tick is the synchronous counter-clock strobe, and gate is asynchronous.
module interval_counter_channel
    import pic_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gate,
    input  logic          ctl_wr,
    input  logic [2:0]    ctl_mode,
    input  logic          ctl_bcd,
    input  logic          load_wr,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count_o,
    output logic          out_o,
    output logic [2:0]    mode_o,
    output logic          bcd_o
);
    logic          gate_lvl, gate_rise;
    pic_mode_e     mode_q;
    logic          armed_q;
    logic [CW:0]   n_q;
    logic [CW+1:0] el_q;
    logic [CW:0]   ph_q;

    pic_gate_sync #(.STAGES(SYNC_STAGES)) u_gsync (
        .clk(clk), .rst_n(rst_n), .gate_async(gate),
        .gate_lvl(gate_lvl), .gate_rise(gate_rise)
    );

    pic_count_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .gate_lvl(gate_lvl), .gate_rise(gate_rise),
        .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_bcd(ctl_bcd),
        .load_wr(load_wr), .load_val(load_val),
        .mode_q(mode_q), .bcd_q(bcd_o), .armed_q(armed_q),
        .n_q(n_q), .el_q(el_q), .ph_q(ph_q), .count_rd(count_o)
    );

    pic_wave_out #(.CW(CW)) u_wave (
        .mode(mode_q), .armed(armed_q), .n(n_q), .el(el_q), .ph(ph_q),
        .out(out_o)
    );

    assign mode_o = mode_q;
endmodule

// File: rtl/pic_channel_checker.sv
// Property checker for the interval counter channel, bound to the top.
module pic_channel_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic          load_wr,
    input logic [CW-1:0] count_o,
    input logic          out_o,
    input logic [2:0]    mode_o
);
    // R1: reset brings output, count and mode to zero.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (out_o == 1'b0 && count_o == '0 && mode_o == 3'd0));

    // R3: the effective mode never shows an aliased code.
    a_r3_mode_folded: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd5);

    // R11: a control write leaves the output at its idle level.
    a_r11_ctl_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (out_o == (mode_o == 3'd3)));

    // R4: mode 0 output stays high until a new write.
    a_r4_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && out_o && !ctl_wr && !load_wr) |=> out_o);

    // R9: a strobe pulse appears only where the count reads zero.
    a_r9_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd4 || mode_o == 3'd5) && $rose(out_o)) |-> (count_o == '0));

    // R6: the one-shot ends exactly when the count reaches zero.
    a_r6_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && $fell(out_o) && !$past(ctl_wr)) |-> (count_o == '0));
endmodule

bind interval_counter_channel pic_channel_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .load_wr(load_wr),
    .count_o(count_o), .out_o(out_o), .mode_o(mode_o)
);

// File: tb/tb_interval_counter_channel.sv
// Scoreboard bench: driver tasks push expectations from a reference
// model, and a monitor pops and compares them at the falling edge.
module tb_interval_counter_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_mode = 3'd0;
    logic        ctl_bcd = 1'b0;
    logic        load_wr = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count_o;
    logic        out_o;
    logic [2:0]  mode_o;
    logic        bcd_o;

    interval_counter_channel dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
        .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_bcd(ctl_bcd),
        .load_wr(load_wr), .load_val(load_val),
        .count_o(count_o), .out_o(out_o), .mode_o(mode_o), .bcd_o(bcd_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    cnt;
        bit    out;
        int    mode;
        bit    bcd;
        bit    chk_cnt;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Reference model state
    int m_mode = 0;
    bit m_bcd = 0;
    bit m_armed = 0;
    bit m_fresh = 1;
    int m_n = 0;
    int m_d = 0;
    bit m_gate = 1;

    function automatic bit lvl_mode(int m);
        return (m == 0) || (m == 4);
    endfunction

    function automatic int model_cnt();
        case (m_mode)
            2:       return (m_n - (m_d % m_n)) & 32'hFFFF;
            3:       return (m_n - ((2 * m_d) % m_n)) & 32'hFFFF;
            default: return (m_n - m_d) & 32'hFFFF;
        endcase
    endfunction

    function automatic bit model_out();
        if (!m_armed) return (m_mode == 3);
        case (m_mode)
            0:       return m_d >= m_n;
            1:       return m_d < m_n;
            2:       return ((m_d % m_n) == 0) && (m_d != 0);
            3:       return (m_d % m_n) < ((m_n + 1) / 2);
            default: return m_d == m_n;
        endcase
    endfunction

    task automatic expect_now(input string tag);
        exp_t e;
        e.cnt     = m_fresh ? 0 : model_cnt();
        e.out     = model_out();
        e.mode    = m_mode;
        e.bcd     = m_bcd;
        e.chk_cnt = m_armed || m_fresh;
        e.tag     = tag;
        sbq.push_back(e);
    endtask

    task automatic do_ctl(input int raw, input bit b);
        @(posedge clk); #1;
        ctl_wr = 1'b1; ctl_mode = raw[2:0]; ctl_bcd = b;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
        m_mode  = (raw > 5) ? raw - 4 : raw;
        m_bcd   = b;
        m_armed = 0;
        m_fresh = 0;
        m_d     = 0;
    endtask

    task automatic do_load(input int v);
        @(posedge clk); #1;
        load_wr = 1'b1; load_val = v[15:0];
        @(posedge clk); #1;
        load_wr = 1'b0;
        m_n     = (v == 0) ? 65536 : v;
        m_d     = 0;
        m_armed = 1;
    endtask

    task automatic do_tick(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
        if (m_armed && (!lvl_mode(m_mode) || m_gate)) m_d += n;
    endtask

    task automatic set_gate(input bit v);
        @(posedge clk); #1;
        gate = v;
        repeat (4) @(posedge clk);
        #1;
        if (v && !m_gate && m_armed && !lvl_mode(m_mode)) m_d = 0;
        m_gate = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pop expectations and compare against the ports.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t e;
            bit   bad;
            e = sbq.pop_front();
            bad = (out_o !== e.out) || (int'(mode_o) != e.mode) || (bcd_o !== e.bcd)
                  || (e.chk_cnt && (int'(count_o) != e.cnt));
            n_cmp++;
            if (bad) begin
                n_bad++;
                $display("FAIL %s: count=%0h exp %0h out=%0b exp %0b mode=%0d exp %0d bcd=%0b exp %0b",
                         e.tag, count_o, e.cnt, out_o, e.out, mode_o, e.mode, bcd_o, e.bcd);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        expect_now("R1 reset state");
        rst_n = 1'b1;
        idle(4);
        m_fresh = 1;
        expect_now("R1 after release");
        m_fresh = 0;

        // Mode 0
        do_ctl(0, 0);   expect_now("R11 idle low mode0");
        do_load(5);     expect_now("R11 load visible");
        do_tick(4);     expect_now("R4 before terminal");
        idle(3);        expect_now("R12 no tick no change");
        do_tick(1);     expect_now("R4 terminal high");
        do_tick(3);     expect_now("R10 wrap mode0");
        set_gate(0);
        do_tick(5);     expect_now("R5 gate low pauses mode0");
        set_gate(1);    expect_now("R5 rise no restart mode0");
        do_tick(1);     expect_now("R5 resumes mode0");

        // Control write mid-count freezes and idles
        do_ctl(0, 0);   expect_now("R11 ctl forces idle");
        do_tick(5);     expect_now("R11 ticks ignored unarmed");

        // Mode 1
        do_ctl(1, 0);   expect_now("R11 idle mode1");
        do_load(4);     expect_now("R6 oneshot start high");
        do_tick(2);     expect_now("R6 mid count");
        set_gate(0);
        set_gate(1);    expect_now("R5 retrigger mode1");
        do_tick(4);     expect_now("R6 oneshot ends");
        do_tick(2);     expect_now("R10 wrap mode1");

        // Mode 6 acts as 2
        do_ctl(6, 1);   expect_now("R3 raw6 reads 2 bcd");
        do_load(3);     expect_now("R7 rate start");
        do_tick(1);     expect_now("R7 count 2");
        do_tick(1);     expect_now("R7 count 1");
        do_tick(1);     expect_now("R7 pulse at N");
        do_tick(1);     expect_now("R7 after pulse");
        do_tick(2);     expect_now("R7 pulse at 2N");
        set_gate(0);    expect_now("R5 level ignored mode2");
        set_gate(1);    expect_now("R5 retrigger mode2");

        // Mode 7 acts as 3
        do_ctl(7, 0);   expect_now("R3 raw7 reads 3 idle high");
        do_load(6);     expect_now("R8 square start");
        do_tick(1);     expect_now("R8 count by two");
        do_tick(2);     expect_now("R8 low half");
        do_tick(3);     expect_now("R8 period wrap");
        do_load(5);
        do_tick(2);     expect_now("R8 odd high phase");
        do_tick(1);     expect_now("R8 odd low phase");

        // Mode 4
        do_ctl(4, 0);   expect_now("R11 idle mode4");
        do_load(3);
        do_tick(2);     expect_now("R9 before strobe");
        do_tick(1);     expect_now("R9 strobe mode4");
        do_tick(1);     expect_now("R9 strobe ends R10 wrap");
        set_gate(0);
        do_tick(3);     expect_now("R5 gate low pauses mode4");
        set_gate(1);
        do_tick(1);     expect_now("R5 resumes mode4");

        // Mode 5
        do_ctl(5, 0);
        do_load(2);
        do_tick(1);     expect_now("R9 mode5 counting");
        set_gate(0);
        set_gate(1);    expect_now("R5 retrigger mode5");
        do_tick(2);     expect_now("R9 strobe mode5");
        do_tick(1);     expect_now("R9 mode5 after strobe");

        // Zero load means 65536
        do_ctl(0, 0);
        do_load(0);     expect_now("R2 zero load reads 0");
        do_tick(65535); expect_now("R2 one count left");
        do_tick(1);     expect_now("R2 terminal at 65536");

        idle(3);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule